// File: doc/BRIEF.md
# Secured configuration store controller

This block models the configuration memory of a small programmable logic device as plain registers. It holds three regions and a security latch. The logic array is a set of words that can be programmed only after an erase. The user signature is a few writable words for identifiers such as ID codes, revision numbers or asset tags. The fixed signature is a read-only identification region whose contents are set by parameters.

A single command port accepts one operation at a time. The operations are erase, program a word, read an array word, read or write a user signature word, read a fixed signature word, and set security. Once security is set, array reads return no stored data and raise a protection flag. The signature regions stay readable so the part can still be identified. The latch clears only when an erase wipes the array, which then allows a new image to be programmed.

Every command is accepted in one cycle and completes with a one-cycle done pulse. A command offered while an earlier one is still running is rejected with an error pulse and has no effect.

Top module: `cfg_guard`

## Requirements
- R1: After reset, busy_o, done_o, err_o, prot_o and rdata_o are all zero. Security is clear, programming is not permitted, and all array and user signature words are zero.
- R2: Opcodes on cmd_op_i are: 0 erase, 1 program, 2 array read, 3 user signature read, 4 user signature write, 5 fixed signature read, 6 set security, 7 reserved. A command sampled with cmd_valid_i while busy_o is low is accepted, and busy_o is high in the following cycle. Read, write, set-security and reserved commands complete one cycle after acceptance. Completion drops busy_o and gives done_o for exactly one cycle.
- R3: A command sampled while busy_o is high is rejected. err_o is high in the next cycle and the command has no effect on any region or on security.
- R4: Erase keeps busy_o high for ARRAY_WORDS cycles. It zeroes every array word and every user signature word, clears security, and permits programming.
- R5: Program keeps busy_o high for PROG_LAT cycles. If programming is permitted, it writes cmd_wdata_i to array word cmd_addr_i. Otherwise it completes with done_o and err_o together and changes nothing.
- R6: When security is clear, an array read returns the stored word on rdata_o with prot_o low, in the done cycle.
- R7: When security is set, an array read returns all ones with prot_o high.
- R8: A user signature write stores cmd_wdata_i at index cmd_addr_i modulo USIG_WORDS. A user signature read returns that word, whether or not security is set.
- R9: A fixed signature read returns FSIG_BASE plus the index (cmd_addr_i modulo FSIG_WORDS), whether or not security is set. The reserved opcode completes with done_o and err_o and changes nothing.
- R10: Set security sets the latch and withdraws programming permission. A later program completes with an error until the next erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered this cycle |
| cmd_op_i | input | 3 | Opcode |
| cmd_addr_i | input | ADDR_W | Word address or signature index |
| cmd_wdata_i | input | WORD_W | Write data |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected or illegal command |
| prot_o | output | 1 | Last read was blocked by security |
| rdata_o | output | WORD_W | Read result, valid with done_o |

## Verification
Two events can land in the same cycle: the completion of one command and the rejection of another. Holding cmd_valid_i high for two cycles around a one-cycle read sets this up. The read completes on the same edge that the second command is refused, so done_o and err_o rise together. The bench model must report the read data unchanged, and it must show that the refused write or program left no trace when that location is read back later. The same overlap is repeated during a long erase, where the refused command arrives mid-sweep.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [2:0] {
    OP_ERASE   = 3'd0,
    OP_PROG    = 3'd1,
    OP_RD_ARR  = 3'd2,
    OP_RD_USIG = 3'd3,
    OP_WR_USIG = 3'd4,
    OP_RD_FSIG = 3'd5,
    OP_SET_SEC = 3'd6,
    OP_RSV     = 3'd7
  } cfg_op_e;
endpackage

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_guard_pkg::*;
#(
  parameter int ARRAY_WORDS = 16,
  parameter int PROG_LAT    = 3,
  parameter int ADDR_W      = 4,
  parameter int WORD_W      = 8,
  parameter int CNT_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  input  logic              erased_i,
  output logic              busy_o,
  output logic              fire_o,
  output cfg_op_e           op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] sweep_idx_o,
  output logic              done_o,
  output logic              err_o
);
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  cfg_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              done_q, err_q;
  logic [CNT_W-1:0]  lat;
  logic              accept, illegal;
  cfg_op_e           new_op;

  assign new_op = cfg_op_e'(cmd_op_i);
  assign accept = cmd_valid_i && !busy_q;
  assign fire_o = busy_q && (cnt_q == '0);

  always_comb begin
    case (new_op)
      OP_ERASE: lat = CNT_W'(ARRAY_WORDS - 1);
      OP_PROG:  lat = CNT_W'(PROG_LAT - 1);
      default:  lat = '0;
    endcase
  end

  assign illegal = (op_q == OP_RSV) || (op_q == OP_PROG && !erased_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      op_q    <= OP_RSV;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= fire_o;
      err_q  <= (cmd_valid_i && busy_q) || (fire_o && illegal);
      if (accept) begin
        busy_q  <= 1'b1;
        cnt_q   <= lat;
        op_q    <= new_op;
        addr_q  <= cmd_addr_i;
        wdata_q <= cmd_wdata_i;
      end else if (busy_q) begin
        if (fire_o) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign op_o        = op_q;
  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
  assign sweep_idx_o = cnt_q[ADDR_W-1:0];
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_guard_pkg::*;
#(
  parameter int ARRAY_WORDS = 16,
  parameter int USIG_WORDS  = 4,
  parameter int ADDR_W      = 4,
  parameter int USIG_AW     = 2,
  parameter int WORD_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              fire_i,
  input  cfg_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] sweep_idx_i,
  output logic [WORD_W-1:0] arr_word_o,
  output logic [WORD_W-1:0] usig_word_o,
  output logic              sec_o,
  output logic              erased_o
);
  logic [WORD_W-1:0] arr_q  [ARRAY_WORDS];
  logic [WORD_W-1:0] usig_q [USIG_WORDS];
  logic              sec_q, erased_q;
  logic [USIG_AW-1:0] uidx;

  assign uidx = addr_i[USIG_AW-1:0];

  // array: one word cleared per erase cycle, programmed on fire
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARRAY_WORDS; i++) arr_q[i] <= '0;
    end else if (busy_i && op_i == OP_ERASE) begin
      arr_q[sweep_idx_i] <= '0;
    end else if (fire_i && op_i == OP_PROG && erased_q) begin
      arr_q[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < USIG_WORDS; i++) usig_q[i] <= '0;
    end else if (fire_i && op_i == OP_ERASE) begin
      for (int i = 0; i < USIG_WORDS; i++) usig_q[i] <= '0;
    end else if (fire_i && op_i == OP_WR_USIG) begin
      usig_q[uidx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q    <= 1'b0;
      erased_q <= 1'b0;
    end else if (fire_i) begin
      if (op_i == OP_ERASE) begin
        sec_q    <= 1'b0;
        erased_q <= 1'b1;
      end else if (op_i == OP_SET_SEC) begin
        sec_q    <= 1'b1;
        erased_q <= 1'b0;
      end
    end
  end

  assign arr_word_o  = arr_q[addr_i];
  assign usig_word_o = usig_q[uidx];
  assign sec_o       = sec_q;
  assign erased_o    = erased_q;
endmodule

// File: rtl/cfg_read.sv
module cfg_read
  import cfg_guard_pkg::*;
#(
  parameter int              WORD_W     = 8,
  parameter int              FSIG_WORDS = 2,
  parameter int              FSIG_AW    = 1,
  parameter logic [WORD_W-1:0] FSIG_BASE = 8'hA5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  cfg_op_e            op_i,
  input  logic               sec_i,
  input  logic [FSIG_AW-1:0] fidx_i,
  input  logic [WORD_W-1:0]  arr_word_i,
  input  logic [WORD_W-1:0]  usig_word_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               prot_o
);
  logic [WORD_W-1:0] fsig_tab [FSIG_WORDS];
  logic [WORD_W-1:0] rd_nxt;
  logic              prot_nxt;

  for (genvar g = 0; g < FSIG_WORDS; g++) begin : g_fsig
    assign fsig_tab[g] = FSIG_BASE + WORD_W'(g);
  end

  always_comb begin
    rd_nxt   = '0;
    prot_nxt = 1'b0;
    case (op_i)
      OP_RD_ARR: begin
        rd_nxt   = sec_i ? '1 : arr_word_i;
        prot_nxt = sec_i;
      end
      OP_RD_USIG: rd_nxt = usig_word_i;
      OP_RD_FSIG: rd_nxt = fsig_tab[fidx_i];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      prot_o  <= 1'b0;
    end else if (fire_i) begin
      rdata_o <= rd_nxt;
      prot_o  <= prot_nxt;
    end
  end
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int                ARRAY_WORDS = 16,
  parameter int                USIG_WORDS  = 4,
  parameter int                FSIG_WORDS  = 2,
  parameter int                WORD_W      = 8,
  parameter int                PROG_LAT    = 3,
  parameter logic [WORD_W-1:0] FSIG_BASE   = 8'hA5,
  localparam int               ADDR_W      = $clog2(ARRAY_WORDS),
  localparam int               USIG_AW     = $clog2(USIG_WORDS),
  localparam int               FSIG_AW     = $clog2(FSIG_WORDS),
  localparam int               MAX_LAT     = (ARRAY_WORDS > PROG_LAT) ? ARRAY_WORDS : PROG_LAT,
  localparam int               CNT_W       = $clog2(MAX_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              prot_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic              fire_w, sec_w, erased_w;
  cfg_op_e           op_w;
  logic [ADDR_W-1:0] addr_w, sweep_w;
  logic [WORD_W-1:0] wdata_w, arr_word_w, usig_word_w;

  cfg_seq #(
    .ARRAY_WORDS(ARRAY_WORDS), .PROG_LAT(PROG_LAT), .ADDR_W(ADDR_W),
    .WORD_W(WORD_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i), .erased_i(erased_w),
    .busy_o(busy_o), .fire_o(fire_w), .op_o(op_w), .addr_o(addr_w), .wdata_o(wdata_w),
    .sweep_idx_o(sweep_w), .done_o(done_o), .err_o(err_o)
  );

  cfg_store #(
    .ARRAY_WORDS(ARRAY_WORDS), .USIG_WORDS(USIG_WORDS), .ADDR_W(ADDR_W),
    .USIG_AW(USIG_AW), .WORD_W(WORD_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_o), .fire_i(fire_w), .op_i(op_w),
    .addr_i(addr_w), .wdata_i(wdata_w), .sweep_idx_i(sweep_w),
    .arr_word_o(arr_word_w), .usig_word_o(usig_word_w), .sec_o(sec_w), .erased_o(erased_w)
  );

  cfg_read #(
    .WORD_W(WORD_W), .FSIG_WORDS(FSIG_WORDS), .FSIG_AW(FSIG_AW), .FSIG_BASE(FSIG_BASE)
  ) u_read (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire_w), .op_i(op_w), .sec_i(sec_w),
    .fidx_i(addr_w[FSIG_AW-1:0]), .arr_word_i(arr_word_w), .usig_word_i(usig_word_w),
    .rdata_o(rdata_o), .prot_o(prot_o)
  );
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              prot_o,
  input logic [WORD_W-1:0] rdata_o,
  input logic              sec_w,
  input logic              erased_w
);
  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_o |=> busy_o);

  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_reject_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && busy_o |=> err_o);

  assert_erase_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(erased_w) |-> done_o);

  assert_prot_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && prot_o |-> rdata_o == '1);

  assert_prot_secured_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && prot_o |-> sec_w);
endmodule

bind cfg_guard cfg_guard_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .prot_o(prot_o), .rdata_o(rdata_o),
  .sec_w(sec_w), .erased_w(erased_w)
);

// File: tb/cfg_guard_bench.sv
module cfg_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int UW   = 4;
  localparam int FW   = 2;
  localparam int PL   = 3;
  localparam logic [7:0] FB = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [3:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic       busy, done, err, prot;
  logic [7:0] rdata;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  cfg_guard #(.ARRAY_WORDS(AW), .USIG_WORDS(UW), .FSIG_WORDS(FW), .WORD_W(8),
              .PROG_LAT(PL), .FSIG_BASE(FB)) u_cfg_guard (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .busy_o(busy), .done_o(done),
    .err_o(err), .prot_o(prot), .rdata_o(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [7:0] m_arr [AW];
  logic [7:0] m_usig [UW];
  bit m_sec, m_erased, m_busy;
  int m_cnt, m_op, m_addr;
  logic [7:0] m_wd;
  bit e_done, e_err, e_prot;
  logic [7:0] e_rdata;

  always @(posedge clk) begin
    bit ob, nd, ne;
    if (!rst_n) begin
      foreach (m_arr[i]) m_arr[i] = 0;
      foreach (m_usig[i]) m_usig[i] = 0;
      m_sec = 0; m_erased = 0; m_busy = 0; m_cnt = 0; m_op = 7; m_addr = 0; m_wd = 0;
      e_done = 0; e_err = 0; e_prot = 0; e_rdata = 0;
    end else begin
      ob = m_busy; nd = 0; ne = 0;
      if (m_busy) begin
        if (m_op == 0) m_arr[m_cnt] = 0;
        if (m_cnt == 0) begin
          nd = 1; m_busy = 0; e_rdata = 0; e_prot = 0;
          case (m_op)
            0: begin foreach (m_usig[i]) m_usig[i] = 0; m_sec = 0; m_erased = 1; end
            1: if (m_erased) m_arr[m_addr] = m_wd; else ne = 1;
            2: begin e_rdata = m_sec ? 8'hFF : m_arr[m_addr]; e_prot = m_sec; end
            3: e_rdata = m_usig[m_addr % UW];
            4: m_usig[m_addr % UW] = m_wd;
            5: e_rdata = FB + 8'(m_addr % FW);
            6: begin m_sec = 1; m_erased = 0; end
            default: ne = 1;
          endcase
        end else m_cnt--;
      end
      if (cmd_valid) begin
        if (ob) ne = 1;
        else begin
          m_busy = 1; m_op = int'(cmd_op); m_addr = int'(cmd_addr); m_wd = cmd_wdata;
          m_cnt = (m_op == 0) ? AW-1 : (m_op == 1) ? PL-1 : 0;
        end
      end
      e_done = nd; e_err = ne;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(m_op == 0 ? "R4 busy" : m_op == 1 ? "R5 busy" : "R2 busy", busy, m_busy);
    chk("R2 done", done, e_done);
    chk((m_op == 1 || m_op == 7) ? "R5/R9 err" : "R3 err", err, e_err);
    if (e_done) begin
      chk(m_op == 2 ? (e_prot ? "R7 rdata" : "R6 rdata") : m_op == 3 ? "R8 rdata" :
          m_op == 5 ? "R9 rdata" : "R2 rdata", rdata, e_rdata);
      chk(e_prot ? "R7 prot" : "R6 prot", prot, e_prot);
    end
  end

  task automatic send(input int op, input int a, input int d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = 4'(a); cmd_wdata = 8'(d);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
    chk("R1 prot", prot, 0); chk("R1 rdata", rdata, 0);
    rst_n = 1;
    send(2, 5, 0); settle();                 // R1 array zero after reset
    send(1, 3, 8'h11); settle();             // R5 program before erase -> error
    send(2, 3, 0); settle();
    send(0, 0, 0); settle();                 // R4 erase
    for (int i = 0; i < AW; i++) begin send(1, i, 8'h30 + i); settle(); end
    for (int i = 0; i < AW; i += 3) begin send(2, i, 0); settle(); end   // R6
    send(4, 1, 8'h5C); settle(); send(4, 6, 8'hE1); settle();            // R8 (6%4=2)
    send(3, 1, 0); settle(); send(3, 2, 0); settle();
    send(5, 0, 0); settle(); send(5, 3, 0); settle();                    // R9
    send(7, 0, 0); settle();                                             // R9 reserved
    // R3: completion and rejection on the same edge
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd2; cmd_addr = 4'd4;
    @(negedge clk); cmd_op = 3'd1; cmd_addr = 4'd4; cmd_wdata = 8'hAA;
    @(negedge clk); cmd_valid = 0; settle();
    send(2, 4, 0); settle();
    // R3: rejection mid-program
    send(1, 7, 8'h77); send(4, 0, 8'h99); settle(); send(3, 0, 0); settle();
    send(2, 7, 0); settle();
    // R10 / R7: security
    send(6, 0, 0); settle();
    send(2, 2, 0); settle(); send(2, 9, 0); settle();                    // R7
    send(3, 1, 0); settle(); send(5, 1, 0); settle();                    // R8 R9 while secured
    send(1, 2, 8'h00); settle(); send(2, 2, 0); settle();                // R10
    // R3 rejection mid-erase, then R4 contents
    send(0, 0, 0); repeat (4) @(negedge clk); send(4, 3, 8'h42); settle();
    send(2, 2, 0); settle(); send(3, 1, 0); settle(); send(3, 3, 0); settle();
    send(1, 2, 8'hC3); settle(); send(2, 2, 0); settle();                // R5 after erase
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule